// File: doc/BRIEF.md
# Chromatic Step Selector for a Rotary Encoder

This block turns detent clicks from a two-pin rotary encoder into a semitone-spaced playback speed for a pitch shifter. It keeps a step index from 0 to 24, where 12 is unshifted playback, and drives a 16-bit speed increment with eight fractional bits. The 25 speeds cover one octave below to one octave above the input pitch in equal-tempered steps, so 0x0100 means normal speed, 0x0080 means half speed and 0x0200 means double speed.

The encoder contacts are assumed to be debounced off-chip. Both pins are passed through a two-flop synchroniser. After that, they are looked at only on every 64th sample-period strobe. A click counts when the first pin (A) is seen low while a latched edge flag is clear. The level of the second pin (B) at that moment gives the direction. The flag stays set until A is seen high at a later inspection, so a contact held low produces one step. The index stops at both ends, and the speed register is reloaded from the table whenever the index moves.

Top module: `encoder_step_select`

## Requirements
- R1: After a synchronous active-low reset, the step index reads 12 and the speed reads 0x0100.
- R2: The encoder is inspected only on the strobe that completes each group of 64 sample strobes counted from reset. Pin activity that returns to idle between two inspections has no effect on the index.
- R3: Each pin passes through two synchronising flip-flops before it is inspected. A change driven on the clock edge just before an inspection is not seen by that inspection.
- R4: A step is registered when an inspection sees A low with the edge flag clear. The flag is then set, and later inspections that still see A low register nothing.
- R5: The edge flag clears only at an inspection that sees A high. After that, the next inspection that sees A low registers a new step.
- R6: On a registered step, B low (a right turn) adds one to the index, and B high (a left turn) subtracts one.
- R7: The index does not go above 24. A right turn at 24 leaves both index and speed unchanged.
- R8: The index does not go below 0. A left turn at 0 leaves both index and speed unchanged.
- R9: The speed output for index 0 through 24 is, in order: 0x0080, 0x0088, 0x0090, 0x0098, 0x00A1, 0x00AB, 0x00B5, 0x00C0, 0x00CB, 0x00D7, 0x00E4, 0x00F2, 0x0100, 0x010F, 0x011F, 0x0130, 0x0143, 0x0156, 0x016A, 0x0180, 0x0196, 0x01AF, 0x01C8, 0x01E3, 0x0200. Index and speed change on the same clock edge, one edge after the inspecting strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_tick | input | 1 | One-cycle strobe per audio sample period |
| enc_a | input | 1 | Encoder pin A; a falling level marks a click |
| enc_b | input | 1 | Encoder pin B; low at a click means a right turn |
| speed | output | 16 | Playback increment, 8.8 fixed point |
| step_idx | output | 5 | Current chromatic step, 0 to 24 |

## Verification
The bench runs several input patterns. Clicks are held for a full inspection window in each direction, which separates the increment path from the decrement path and checks every table entry on the way. A held-low A across several windows separates the latched flag from plain level sensing. An A pulse that falls and rises between inspections shows that only the 64th strobe samples. A change made on the clock edge just before an inspection exposes the synchroniser depth. Long runs past both ends confirm that the index saturates and does not wrap.

// File: rtl/pitchstep_pkg.sv
// Shared constants and the chromatic speed table for the step selector.
// Assumes 8.8 fixed-point speeds, with 0x0100 as unshifted playback.
package pitchstep_pkg;

    localparam int STEP_COUNT = 25;
    localparam int STEP_HOME  = 12;
    localparam int IDX_W      = $clog2(STEP_COUNT);
    localparam int SPEED_W    = 16;

    typedef logic [IDX_W-1:0]   step_t;
    typedef logic [SPEED_W-1:0] speed_t;

    // Equal-tempered increment for each step, half speed up to double speed
    function automatic speed_t speed_of(input step_t i);
        case (i)
            5'd0:    speed_of = 16'h0080;
            5'd1:    speed_of = 16'h0088;
            5'd2:    speed_of = 16'h0090;
            5'd3:    speed_of = 16'h0098;
            5'd4:    speed_of = 16'h00A1;
            5'd5:    speed_of = 16'h00AB;
            5'd6:    speed_of = 16'h00B5;
            5'd7:    speed_of = 16'h00C0;
            5'd8:    speed_of = 16'h00CB;
            5'd9:    speed_of = 16'h00D7;
            5'd10:   speed_of = 16'h00E4;
            5'd11:   speed_of = 16'h00F2;
            5'd12:   speed_of = 16'h0100;
            5'd13:   speed_of = 16'h010F;
            5'd14:   speed_of = 16'h011F;
            5'd15:   speed_of = 16'h0130;
            5'd16:   speed_of = 16'h0143;
            5'd17:   speed_of = 16'h0156;
            5'd18:   speed_of = 16'h016A;
            5'd19:   speed_of = 16'h0180;
            5'd20:   speed_of = 16'h0196;
            5'd21:   speed_of = 16'h01AF;
            5'd22:   speed_of = 16'h01C8;
            5'd23:   speed_of = 16'h01E3;
            default: speed_of = 16'h0200;
        endcase
    endfunction

endpackage

// File: rtl/enc_sync.sv
// Multi-stage synchroniser for asynchronous encoder pins.
// Assumes the pins idle high; every stage resets to 1.
module enc_sync #(
    parameter int N_PINS = 2,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    output logic [N_PINS-1:0] pin_o
);

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        logic [STAGES-1:0] chain_q;

        // Shift the raw pin level through the synchroniser chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], pin_i[p]};
        end

        assign pin_o[p] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/scan_pacer.sv
// Counts sample strobes and raises a one-cycle inspect pulse on every
// DIV-th strobe. Assumes each strobe is a single-cycle pulse.
module scan_pacer #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic scan_o
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign scan_o = tick_i && (cnt_q == LAST);

    // Advance the strobe count, wrapping after the inspecting strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (scan_o) cnt_q <= '0;
        else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_q));

endmodule

// File: rtl/turn_detect.sv
// Decides on each inspection whether a click occurred and which way.
// Holds a latched edge flag so that a held-low A yields one step only.
module turn_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scan_i,
    input  logic a_i,
    input  logic b_i,
    output logic up_o,
    output logic dn_o
);

    logic flag_q;
    logic fresh;

    assign fresh = scan_i && !a_i && !flag_q;
    assign up_o  = fresh && !b_i;
    assign dn_o  = fresh &&  b_i;

    // Set the flag on a new click, clear it once A is seen high
    always_ff @(posedge clk) begin
        if (!rst_n)               flag_q <= 1'b0;
        else if (scan_i &&  a_i)  flag_q <= 1'b0;
        else if (fresh)           flag_q <= 1'b1;
    end

    p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(scan_i && !a_i));

    p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(scan_i && a_i));

endmodule

// File: rtl/step_track.sv
// Saturating step index and its registered table speed.
// Assumes up and down requests never arrive together.
module step_track
    import pitchstep_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   up_i,
    input  logic   dn_i,
    output step_t  idx_o,
    output speed_t speed_o
);

    localparam step_t TOP  = step_t'(STEP_COUNT - 1);
    localparam step_t HOME = step_t'(STEP_HOME);

    step_t  idx_q, idx_n;
    speed_t speed_q;

    // Pick the next index, stopping at both ends
    always_comb begin
        idx_n = idx_q;
        if (up_i && idx_q < TOP)          idx_n = idx_q + 1'b1;
        else if (dn_i && idx_q != '0)     idx_n = idx_q - 1'b1;
    end

    // Register the index and reload the speed whenever it moves
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= HOME;
            speed_q <= speed_of(HOME);
        end else if (idx_n != idx_q) begin
            idx_q   <= idx_n;
            speed_q <= speed_of(idx_n);
        end
    end

    assign idx_o   = idx_q;
    assign speed_o = speed_q;

    p_idx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= TOP);

    p_sat_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q == TOP && up_i && !dn_i) |=> idx_q == TOP);

    p_sat_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q == '0 && dn_i && !up_i) |=> idx_q == '0);

    p_quiet_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_i && !dn_i) |=> $stable(idx_q));

    p_speed_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(idx_q) |-> $stable(speed_q));

endmodule

// File: rtl/encoder_step_select.sv
// Top level: synchronises the encoder pins, paces the inspections,
// detects clicks and tracks the chromatic step and its speed.
module encoder_step_select
    import pitchstep_pkg::*;
#(
    parameter int SCAN_DIV    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_tick,
    input  logic               enc_a,
    input  logic               enc_b,
    output logic [SPEED_W-1:0] speed,
    output logic [IDX_W-1:0]   step_idx
);

    logic [1:0] pins_s;
    logic       scan, up, dn;

    enc_sync #(.N_PINS(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({enc_b, enc_a}),
        .pin_o (pins_s)
    );

    scan_pacer #(.DIV(SCAN_DIV)) u_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (sample_tick),
        .scan_o (scan)
    );

    turn_detect u_turn (
        .clk    (clk),
        .rst_n  (rst_n),
        .scan_i (scan),
        .a_i    (pins_s[0]),
        .b_i    (pins_s[1]),
        .up_o   (up),
        .dn_o   (dn)
    );

    step_track u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_i    (up),
        .dn_i    (dn),
        .idx_o   (step_idx),
        .speed_o (speed)
    );

    p_steps_on_scan_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !scan |=> $stable(step_idx));

endmodule

// File: tb/encoder_step_select_tb.sv
module encoder_step_select_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_tick = 1'b0;
    logic        enc_a = 1'b1;
    logic        enc_b = 1'b1;
    logic [15:0] speed;
    logic [4:0]  step_idx;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    localparam logic [15:0] TBL [25] = '{
        16'h0080, 16'h0088, 16'h0090, 16'h0098, 16'h00A1, 16'h00AB, 16'h00B5,
        16'h00C0, 16'h00CB, 16'h00D7, 16'h00E4, 16'h00F2, 16'h0100, 16'h010F,
        16'h011F, 16'h0130, 16'h0143, 16'h0156, 16'h016A, 16'h0180, 16'h0196,
        16'h01AF, 16'h01C8, 16'h01E3, 16'h0200};

    always #10 clk = ~clk;

    encoder_step_select u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (sample_tick),
        .enc_a       (enc_a),
        .enc_b       (enc_b),
        .speed       (speed),
        .step_idx    (step_idx)
    );

    // Behavioural reference: pin history, strobe count, flag, index
    int  m_idx = 12;
    int  m_cnt = 0;
    bit  m_flag = 0;
    bit  qa[$];
    bit  qb[$];
    bit  m_live = 0;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_idx = 12; m_cnt = 0; m_flag = 0;
            qa = '{1'b1, 1'b1}; qb = '{1'b1, 1'b1};
            m_live = 1;
        end else begin
            bit sa, sb;
            sa = qa[0]; sb = qb[0];
            if (sample_tick) begin
                if (m_cnt == 63) begin
                    m_cnt = 0;
                    if (sa) m_flag = 0;
                    else if (!m_flag) begin
                        m_flag = 1;
                        if (!sb && m_idx < 24) m_idx++;
                        else if (sb && m_idx > 0) m_idx--;
                    end
                end else m_cnt++;
            end
            void'(qa.pop_front()); void'(qb.pop_front());
            qa.push_back(enc_a); qb.push_back(enc_b);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Clock-by-clock comparison against the reference (R1 R6 R7 R8 R9)
    always @(negedge clk) begin
        if (m_live && !done) begin
            chk(step_idx == 5'(m_idx), "R6/R7/R8 index vs model", step_idx, m_idx);
            chk(speed == TBL[m_idx], "R9 speed vs table", speed, TBL[m_idx]);
        end
    end

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sample_tick = 1'b1;
            @(negedge clk) sample_tick = 1'b0;
        end
    endtask

    task automatic window(input bit a, input bit b);
        @(negedge clk) begin enc_a = a; enc_b = b; end
        strobes(64);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(step_idx == 5'd12, "R1 reset index", step_idx, 12);
        chk(speed == 16'h0100, "R1 reset speed", speed, 16'h0100);

        // R2: 63 strobes with a click held give no step, the 64th does
        @(negedge clk) begin enc_a = 1'b0; enc_b = 1'b0; end
        strobes(63);
        chk(step_idx == 5'd12, "R2 no step before 64th strobe", step_idx, 12);
        strobes(1);
        chk(step_idx == 5'd13, "R6 right turn increments", step_idx, 13);
        chk(speed == 16'h010F, "R9 speed at step 13", speed, 16'h010F);

        // R4: A held low over more windows adds nothing
        window(1'b0, 1'b0);
        window(1'b0, 1'b0);
        chk(step_idx == 5'd13, "R4 held low gives one step", step_idx, 13);

        // R5: A seen high clears the flag; a left click then decrements
        window(1'b1, 1'b1);
        chk(step_idx == 5'd13, "R5 release makes no step", step_idx, 13);
        window(1'b0, 1'b1);
        chk(step_idx == 5'd12, "R6 left turn decrements", step_idx, 12);
        window(1'b1, 1'b1);

        // R2: a pulse on A that ends between inspections is ignored
        @(negedge clk) enc_a = 1'b1;
        strobes(30);
        @(negedge clk) begin enc_a = 1'b0; enc_b = 1'b0; end
        strobes(20);
        @(negedge clk) enc_a = 1'b1;
        strobes(14);
        chk(step_idx == 5'd12, "R2 pulse between inspections ignored", step_idx, 12);

        // R3: a change on the edge just before an inspection is not seen
        strobes(63);
        @(negedge clk) begin enc_a = 1'b0; enc_b = 1'b0; sample_tick = 1'b1; end
        @(negedge clk) sample_tick = 1'b0;
        chk(step_idx == 5'd12, "R3 synchroniser delay hides late change", step_idx, 12);
        strobes(64);
        chk(step_idx == 5'd13, "R3 change seen at next inspection", step_idx, 13);
        window(1'b1, 1'b0);

        // R7: climb past the top
        for (int k = 0; k < 14; k++) begin
            window(1'b0, 1'b0);
            window(1'b1, 1'b0);
        end
        chk(step_idx == 5'd24, "R7 index saturates at 24", step_idx, 24);
        chk(speed == 16'h0200, "R7 speed at top", speed, 16'h0200);

        // R8: descend past the bottom
        for (int k = 0; k < 27; k++) begin
            window(1'b0, 1'b1);
            window(1'b1, 1'b1);
        end
        chk(step_idx == 5'd0, "R8 index saturates at 0", step_idx, 0);
        chk(speed == 16'h0080, "R8 speed at bottom", speed, 16'h0080);

        // R9: a few steps up from the bottom follow the table
        window(1'b0, 1'b0);
        chk(speed == 16'h0088, "R9 speed at step 1", speed, 16'h0088);
        window(1'b1, 1'b0);
        window(1'b0, 1'b0);
        chk(speed == 16'h0090, "R9 speed at step 2", speed, 16'h0090);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule